// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block generates data-memory addresses from four 16-bit index pointers. On each request it picks one pointer and one modifier, then produces an address. The modifier comes either from one of four modify registers or from a signed 8-bit immediate in the request. In pre-modify form the address is the pointer plus the modifier, and the pointer is left unchanged. In post-modify form the address is the pointer itself, and the pointer then advances by the modifier.

Each pointer has its own base and length registers. A nonzero length confines updates to the circular window that starts at the base and spans that many words. A zero length gives plain linear updates that wrap modulo 2^16. All registers are written through one load port that carries a kind code, a register number and a data word. The address appears on a registered output one cycle after the request, together with a done strobe.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, every index, modify, length and base register is zero, `addrOut` is zero and `addrDone` is low.
- R2: When `ldEn` is high, `ldData` is written into register `ldIdx` of the kind given by `ldKind`: 0 index, 1 modify, 2 length, 3 base.
- R3: `addrDone` is high in exactly the cycle after a cycle with `reqValid` high, and `addrOut` carries that request's address in the same cycle.
- R4: A post-modify request (`reqPre`=0) outputs the pointer's current value and writes the updated value back into the pointer.
- R5: A pre-modify request (`reqPre`=1) outputs the updated value and leaves the pointer unchanged.
- R6: With `reqUseImm`=0 the modifier is modify register `reqMod`, which any request may use with any pointer.
- R7: With `reqUseImm`=1 the modifier is `reqImm` read as two's complement and sign-extended to 16 bits, in both pre- and post-modify forms.
- R8: With length zero the updated value is pointer plus modifier modulo 2^16.
- R9: With length L nonzero and base B, a sum at or above B+L has L subtracted and a sum below B has L added. This holds for a pointer inside the window and a modifier of magnitude no more than L.
- R10: When a load and a request share a cycle, the request reads the register values from before the load. If both target the same index register, the post-modify writeback is the value that remains.
- R11: In a cycle without a request, `addrOut` holds its value and no pointer changes except through the load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ldEn | input | 1 | Register load strobe |
| ldKind | input | 2 | Register kind: 0 index, 1 modify, 2 length, 3 base |
| ldIdx | input | 2 | Register number within the kind |
| ldData | input | 16 | Load value |
| reqValid | input | 1 | Address request strobe |
| reqPtr | input | 2 | Index pointer to use |
| reqPre | input | 1 | 1 pre-modify, 0 post-modify |
| reqUseImm | input | 1 | 1 immediate modifier, 0 modify register |
| reqMod | input | 2 | Modify register number |
| reqImm | input | 8 | Signed immediate modifier |
| addrOut | output | 16 | Registered address |
| addrDone | output | 1 | Address valid strobe |

## Verification
The assertions check on every cycle that the done strobe follows the request by exactly one cycle, that the output and pointers stay still without a request, that pre-modify never disturbs its pointer, and that a circular update from inside a window lands back inside it. Only the bench scenarios can show the actual address values. These include the sign extension of immediates, the wrap at both ends of a window, 16-bit rollover with length zero, and the resolution of a load and a request in the same cycle.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int AGEN_W     = 16;
  localparam int AGEN_NREG  = 4;
  localparam int AGEN_SEL_W = $clog2(AGEN_NREG);
  localparam int AGEN_IMM_W = 8;

  typedef enum logic [1:0] {
    KIND_INDEX  = 2'd0,
    KIND_MODIFY = 2'd1,
    KIND_LENGTH = 2'd2,
    KIND_BASE   = 2'd3
  } ldKind_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic [AGEN_NREG-1:0] wrIndex;
    logic [AGEN_NREG-1:0] wrModify;
    logic [AGEN_NREG-1:0] wrLength;
    logic [AGEN_NREG-1:0] wrBase;
    logic                 access;
    logic                 pre;
    logic                 useImm;
  } agenStrobe_t;
endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
#(
  parameter int NREG  = AGEN_NREG,
  parameter int SEL_W = AGEN_SEL_W
) (
  input  logic             ldEn,
  input  logic [1:0]       ldKind,
  input  logic [SEL_W-1:0] ldIdx,
  input  logic             reqValid,
  input  logic             reqPre,
  input  logic             reqUseImm,
  output agenStrobe_t      strb
);
  logic [NREG-1:0] selOneHot;

  always_comb begin
    selOneHot = '0;
    selOneHot[ldIdx] = 1'b1;
  end

  always_comb begin
    strb          = '0;
    strb.access   = reqValid;
    strb.pre      = reqValid & reqPre;
    strb.useImm   = reqValid & reqUseImm;
    if (ldEn) begin
      unique case (ldKind_e'(ldKind))
        KIND_INDEX:  strb.wrIndex  = selOneHot;
        KIND_MODIFY: strb.wrModify = selOneHot;
        KIND_LENGTH: strb.wrLength = selOneHot;
        KIND_BASE:   strb.wrBase   = selOneHot;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/agen_wrap.sv
module agen_wrap #(
  parameter int W = 16
) (
  input  logic [W-1:0] ptr,
  input  logic [W-1:0] modv,
  input  logic [W-1:0] base,
  input  logic [W-1:0] len,
  output logic [W-1:0] nextPtr
);
  localparam int XW = W + 2;

  logic [W-1:0]         rel;
  logic signed [XW-1:0] relSum;
  logic signed [XW-1:0] lenExt;
  logic signed [XW-1:0] relAdj;

  always_comb begin
    rel    = ptr - base;
    relSum = $signed({2'b00, rel}) + $signed({{2{modv[W-1]}}, modv});
    lenExt = $signed({2'b00, len});
    if (relSum < 0)            relAdj = relSum + lenExt;
    else if (relSum >= lenExt) relAdj = relSum - lenExt;
    else                       relAdj = relSum;
    if (len == '0) nextPtr = ptr + modv;
    else           nextPtr = base + relAdj[W-1:0];
  end

  // R9: from inside the window with a bounded step, the result stays inside
  logic [W:0] modMag;
  logic [W-1:0] nextRel;
  always_comb begin
    modMag  = modv[W-1] ? ({1'b0, ~modv} + 1'b1) : {1'b0, modv};
    nextRel = nextPtr - base;
    if (len != '0 && rel < len && modMag <= {1'b0, len})
      assert_in_window_R9: assert (nextRel < len);
  end
endmodule

// File: rtl/agen_datapath.sv
module agen_datapath
  import agen_pkg::*;
#(
  parameter int W     = AGEN_W,
  parameter int NREG  = AGEN_NREG,
  parameter int SEL_W = AGEN_SEL_W,
  parameter int IMM_W = AGEN_IMM_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  agenStrobe_t      strb,
  input  logic [W-1:0]     ldData,
  input  logic [SEL_W-1:0] reqPtr,
  input  logic [SEL_W-1:0] reqMod,
  input  logic [IMM_W-1:0] reqImm,
  output logic [W-1:0]     addrOut,
  output logic             addrDone
);
  logic [W-1:0] idxR  [NREG];
  logic [W-1:0] modR  [NREG];
  logic [W-1:0] lenR  [NREG];
  logic [W-1:0] baseR [NREG];

  logic [W-1:0] curPtr, modVal, nextPtr;

  assign curPtr = idxR[reqPtr];
  assign modVal = strb.useImm ? {{(W-IMM_W){reqImm[IMM_W-1]}}, reqImm}
                              : modR[reqMod];

  agen_wrap #(.W(W)) u_wrap (
    .ptr    (curPtr),
    .modv   (modVal),
    .base   (baseR[reqPtr]),
    .len    (lenR[reqPtr]),
    .nextPtr(nextPtr)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_regs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idxR[g]  <= '0;
        modR[g]  <= '0;
        lenR[g]  <= '0;
        baseR[g] <= '0;
      end else begin
        if (strb.wrModify[g]) modR[g]  <= ldData;
        if (strb.wrLength[g]) lenR[g]  <= ldData;
        if (strb.wrBase[g])   baseR[g] <= ldData;
        // load first, post-modify writeback last so it prevails
        if (strb.wrIndex[g])  idxR[g]  <= ldData;
        if (strb.access && !strb.pre && reqPtr == SEL_W'(g))
          idxR[g] <= nextPtr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut  <= '0;
      addrDone <= 1'b0;
    end else begin
      addrDone <= strb.access;
      if (strb.access) addrOut <= strb.pre ? nextPtr : curPtr;
    end
  end

  // R3: done follows a request by exactly one cycle
  assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.access |=> addrDone);
  assert_done_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.access |=> !addrDone);
  // R11: no request, output holds
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.access |=> $stable(addrOut));
  // R11: no request and no index load, pointer 0 holds
  assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.access && !strb.wrIndex[0]) |=> $stable(idxR[0]));
  // R5: pre-modify leaves its pointer as it was
  assert_pre_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pre && strb.wrIndex == '0) |=> idxR[$past(reqPtr)] == $past(curPtr));
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import agen_pkg::*;
#(
  parameter int W     = AGEN_W,
  parameter int SEL_W = AGEN_SEL_W,
  parameter int IMM_W = AGEN_IMM_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldEn,
  input  logic [1:0]       ldKind,
  input  logic [SEL_W-1:0] ldIdx,
  input  logic [W-1:0]     ldData,
  input  logic             reqValid,
  input  logic [SEL_W-1:0] reqPtr,
  input  logic             reqPre,
  input  logic             reqUseImm,
  input  logic [SEL_W-1:0] reqMod,
  input  logic [IMM_W-1:0] reqImm,
  output logic [W-1:0]     addrOut,
  output logic             addrDone
);
  agenStrobe_t strb;

  agen_ctrl #(.NREG(AGEN_NREG), .SEL_W(SEL_W)) u_ctrl (
    .ldEn     (ldEn),
    .ldKind   (ldKind),
    .ldIdx    (ldIdx),
    .reqValid (reqValid),
    .reqPre   (reqPre),
    .reqUseImm(reqUseImm),
    .strb     (strb)
  );

  agen_datapath #(.W(W), .NREG(AGEN_NREG), .SEL_W(SEL_W), .IMM_W(IMM_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .ldData  (ldData),
    .reqPtr  (reqPtr),
    .reqMod  (reqMod),
    .reqImm  (reqImm),
    .addrOut (addrOut),
    .addrDone(addrDone)
  );
endmodule

// File: tb/sim_circ_addr_gen.sv
module sim_circ_addr_gen;
  typedef struct packed {
    logic        isReq;
    logic [1:0]  kind;
    logic [1:0]  idx;
    logic        pre;
    logic        useImm;
    logic [1:0]  modSel;
    logic [7:0]  imm;
    logic [15:0] data;
    logic [15:0] expAddr;
  } vec_t;

  function automatic vec_t mkLd(logic [1:0] k, logic [1:0] i, logic [15:0] d);
    mkLd = '{isReq:1'b0, kind:k, idx:i, pre:1'b0, useImm:1'b0, modSel:2'd0,
             imm:8'd0, data:d, expAddr:16'd0};
  endfunction
  function automatic vec_t mkRq(logic [1:0] p, logic pr, logic ui, logic [1:0] m,
                                logic [7:0] im, logic [15:0] e);
    mkRq = '{isReq:1'b1, kind:2'd0, idx:p, pre:pr, useImm:ui, modSel:m,
             imm:im, data:16'd0, expAddr:e};
  endfunction

  localparam int NV = 25;
  // kind: 0 index, 1 modify, 2 length, 3 base
  localparam vec_t VECS [NV] = '{
    mkLd(2'd0, 2'd0, 16'h1000), mkLd(2'd1, 2'd0, 16'h0004),
    mkLd(2'd1, 2'd1, 16'hFFFE),
    mkRq(2'd0, 1'b0, 1'b0, 2'd0, 8'h00, 16'h1000), // R4 R6 post mod0
    mkRq(2'd0, 1'b0, 1'b1, 2'd0, 8'h00, 16'h1004), // R4 writeback seen
    mkRq(2'd0, 1'b1, 1'b0, 2'd1, 8'h00, 16'h1002), // R5 R6 pre mod1=-2
    mkRq(2'd0, 1'b0, 1'b1, 2'd0, 8'h00, 16'h1004), // R5 pointer kept
    mkRq(2'd0, 1'b1, 1'b1, 2'd0, 8'h80, 16'h0F84), // R7 pre imm -128
    mkRq(2'd0, 1'b0, 1'b1, 2'd0, 8'h7F, 16'h1004), // R7 post imm +127
    mkRq(2'd0, 1'b0, 1'b1, 2'd0, 8'h00, 16'h1083), // R7 result
    mkLd(2'd0, 2'd1, 16'hFFFE),
    mkRq(2'd1, 1'b0, 1'b1, 2'd0, 8'h04, 16'hFFFE), // R8
    mkRq(2'd1, 1'b0, 1'b1, 2'd0, 8'h00, 16'h0002), // R8 rollover
    mkLd(2'd3, 2'd2, 16'h0200), mkLd(2'd2, 2'd2, 16'h0008),
    mkLd(2'd0, 2'd2, 16'h0206), mkLd(2'd1, 2'd2, 16'h0003),
    mkRq(2'd2, 1'b0, 1'b0, 2'd2, 8'h00, 16'h0206), // R9 +3 -> wraps to 0x201
    mkRq(2'd2, 1'b0, 1'b1, 2'd0, 8'hFB, 16'h0201), // R9 -5 -> 0x204
    mkRq(2'd2, 1'b1, 1'b0, 2'd2, 8'h00, 16'h0207), // R9 pre to top word
    mkRq(2'd2, 1'b1, 1'b1, 2'd0, 8'h04, 16'h0200), // R9 exactly B+L -> B
    mkRq(2'd2, 1'b0, 1'b1, 2'd0, 8'h00, 16'h0204), // R9 pointer 0x204
    mkLd(2'd1, 2'd3, 16'h0000),
    mkRq(2'd2, 1'b1, 1'b1, 2'd0, 8'hFC, 16'h0200), // R9 down to base
    mkRq(2'd2, 1'b1, 1'b1, 2'd0, 8'hFB, 16'h0207)  // R9 below base
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldEn = 1'b0;
  logic [1:0]  ldKind = '0;
  logic [1:0]  ldIdx = '0;
  logic [15:0] ldData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqPtr = '0;
  logic        reqPre = 1'b0;
  logic        reqUseImm = 1'b0;
  logic [1:0]  reqMod = '0;
  logic [7:0]  reqImm = '0;
  logic [15:0] addrOut;
  logic        addrDone;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  circ_addr_gen u0 (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldKind(ldKind), .ldIdx(ldIdx),
    .ldData(ldData), .reqValid(reqValid), .reqPtr(reqPtr), .reqPre(reqPre),
    .reqUseImm(reqUseImm), .reqMod(reqMod), .reqImm(reqImm),
    .addrOut(addrOut), .addrDone(addrDone)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ldEn = 1'b0; reqValid = 1'b0;
  endtask

  // drive one cycle starting at a falling edge; returns at the next falling edge
  task automatic drive(logic le, logic [1:0] k, logic [1:0] li, logic [15:0] d,
                       logic rv, logic [1:0] p, logic pr, logic ui,
                       logic [1:0] m, logic [7:0] im);
    ldEn = le; ldKind = k; ldIdx = li; ldData = d;
    reqValid = rv; reqPtr = p; reqPre = pr; reqUseImm = ui; reqMod = m; reqImm = im;
    @(negedge clk);
    idle();
  endtask

  task automatic readPtr(logic [1:0] p, string req, logic [15:0] exp);
    drive(1'b0, 2'd0, 2'd0, 16'd0, 1'b1, p, 1'b0, 1'b1, 2'd0, 8'h00);
    check(req, addrOut, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nFails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 done", {15'd0, addrDone}, 16'd0);
    check("R1 addr", addrOut, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    readPtr(2'd3, "R1 index3", 16'h0000);
    check("R3 done with address", {15'd0, addrDone}, 16'd1);
    @(negedge clk);
    check("R3 done drops", {15'd0, addrDone}, 16'd0);
    check("R11 addr held", addrOut, 16'h0000);

    foreach (VECS[i]) begin
      drive(~VECS[i].isReq, VECS[i].kind, VECS[i].idx, VECS[i].data,
            VECS[i].isReq, VECS[i].idx, VECS[i].pre, VECS[i].useImm,
            VECS[i].modSel, VECS[i].imm);
      if (VECS[i].isReq) begin
        check($sformatf("R2 R4-R9 vector %0d", i), addrOut, VECS[i].expAddr);
        check($sformatf("R3 vector %0d done", i), {15'd0, addrDone}, 16'd1);
      end
    end

    // R11: idle cycles leave pointer 2 and the output alone
    repeat (3) @(negedge clk);
    check("R11 addr held idle", addrOut, 16'h0207);
    readPtr(2'd2, "R11 pointer2 held", 16'h0204);

    // R10: load index3 and post-modify index3 in one cycle
    drive(1'b1, 2'd0, 2'd3, 16'h5000, 1'b1, 2'd3, 1'b0, 1'b1, 2'd0, 8'h01);
    check("R10 access uses old pointer", addrOut, 16'h0000);
    readPtr(2'd3, "R10 writeback prevails", 16'h0001);
    // R10: load index0 while accessing index3
    drive(1'b1, 2'd0, 2'd0, 16'h7000, 1'b1, 2'd3, 1'b1, 1'b1, 2'd0, 8'h05);
    check("R10 other pointer access", addrOut, 16'h0006);
    readPtr(2'd0, "R10 load applied", 16'h7000);
    // R10: load modify3 while pre-modifying with modify3
    drive(1'b1, 2'd1, 2'd3, 16'h0009, 1'b1, 2'd3, 1'b1, 1'b0, 2'd3, 8'h00);
    check("R10 old modify value", addrOut, 16'h0001);
    drive(1'b0, 2'd0, 2'd0, 16'h0, 1'b1, 2'd3, 1'b1, 1'b0, 2'd3, 8'h00);
    check("R6 R10 new modify value", addrOut, 16'h000A);

    // R1: reset clears registers
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset addr", addrOut, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    readPtr(2'd0, "R1 index0 cleared", 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule